// File: doc/BRIEF.md
# Interrupt and Clock-Speed Control Register Bank

This block is a small register bank on the processor's I/O bus. It keeps a five-bit pending-interrupt flag set and an eight-bit interrupt mask. It collects single-cycle request pulses from five sources: vertical blank, display status, timer, serial link and keypad. Its output is the vector of interrupts that are both pending and enabled. Dispatching those interrupts belongs to the processor, not to this block.

The bank also holds two further registers. The first is a compatibility register, which latches a legacy-mode indication. The second is a clock-speed register, which software uses to arm a change between normal and double speed. An armed change takes effect when the processor issues its stop strobe. At that point the speed output toggles and the arm bit clears. The clock generator that acts on the speed output is outside this block.

Reads are combinational from the low byte of the I/O address. Writes take effect on the rising clock edge.

Top module: `irqspd_regs`

## Requirements
- R1: After synchronous reset, the following are all zero: every flag, the mask, the compatibility register, the speed bit, the arm bit, the legacy output and the pending vector.
- R2: A write to flag address 0x0F loads flag bits 4:0 from write-data bits 4:0. Bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is keypad. A read of 0x0F returns the flags in bits 4:0 and zero in bits 7:5.
- R3: A request pulse on `irq_req[i]` sets flag i at the next clock edge. If a bus write to 0x0F in the same cycle would clear that bit, the request wins and the bit is set.
- R4: The mask at address 0xFF is a full eight-bit register. It reads back exactly what was last written.
- R5: `irq_pending` equals mask bits 4:0 AND flag bits 4:0.
- R6: A write to speed address 0x4D sets the arm bit from write-data bit 0, and the other written bits are ignored. A read of 0x4D returns the speed in bit 7 (1 = double), the arm bit in bit 0 and zero elsewhere.
- R7: When `cpu_stop` is high and the arm bit is set, the speed toggles and the arm bit clears at that edge. When `cpu_stop` is high and the arm bit is clear, the speed does not change. `speed_double` always shows the current speed.
- R8: The compatibility register at 0x4C is read/write. Writing the value 0x04 sets `legacy_mode`, which then stays set until reset, whatever is written afterwards.
- R9: A read of any other address returns 0x00. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Low byte of the I/O address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_req | input | 5 | Request pulses from the five sources |
| cpu_stop | input | 1 | Stop strobe that performs an armed speed change |
| irq_pending | output | 5 | Interrupts that are both enabled and pending |
| speed_double | output | 1 | 1 while running at double speed |
| legacy_mode | output | 1 | Sticky legacy-compatibility indication |

## Verification
A corrupted flag shows up on `irq_pending` in the cycle after the edge, as long as its mask bit is set. It also shows up on any read of 0x0F. A corrupted speed or arm bit first appears on the next read of 0x4D or on `speed_double`. If it is not caught there, the next stop strobe either toggles the speed when it should not, or fails to toggle it, and that error persists until software acts. A lost legacy bit can only be seen on `legacy_mode`, and it stays wrong until reset. The sweeps therefore read back after every single write and after every strobe.

// File: rtl/irqspd_pkg.sv
package irqspd_pkg;

    localparam int BUS_W   = 8;
    localparam int NUM_SRC = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FLAG,
        SEL_MASK,
        SEL_COMPAT,
        SEL_SPEED
    } reg_sel_e;

    typedef struct packed {
        logic double_spd;
        logic armed;
    } speed_state_t;

    function automatic logic [BUS_W-1:0] speed_readback(speed_state_t s);
        logic [BUS_W-1:0] v;
        v = '0;
        v[BUS_W-1] = s.double_spd;
        v[0]       = s.armed;
        return v;
    endfunction

    function automatic logic [BUS_W-1:0] widen_flags(logic [NUM_SRC-1:0] f);
        logic [BUS_W-1:0] v;
        v = '0;
        v[NUM_SRC-1:0] = f;
        return v;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irqspd_pkg::*;
#(
    parameter int SRC_N  = NUM_SRC,
    parameter int DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_flag,
    input  logic              wr_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_N-1:0]  req,
    output logic [SRC_N-1:0]  flags,
    output logic [DATA_W-1:0] mask,
    output logic [SRC_N-1:0]  pending
);

    generate
        for (genvar i = 0; i < SRC_N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)            flags[i] <= 1'b0;
                else if (req[i])    flags[i] <= 1'b1;
                else if (wr_flag)   flags[i] <= wdata[i];
            end

            // R3: a request pulse always leaves its flag set
            a_r3_req_sets: assert property (@(posedge clk) disable iff (rst)
                req[i] |=> flags[i]);
            // R2: a write without a competing request loads the bit
            a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
                (wr_flag && !req[i]) |=> (flags[i] == $past(wdata[i])));
            // R2: with neither a request nor a write, the flag holds
            a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
                (!wr_flag && !req[i]) |=> $stable(flags[i]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          mask <= '0;
        else if (wr_mask) mask <= wdata;
    end

    assign pending = mask[SRC_N-1:0] & flags;

    // R4: the mask takes the full written byte
    a_r4_mask_load: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask == $past(wdata)));

endmodule

// File: rtl/speed_ctl.sv
module speed_ctl
    import irqspd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_speed,
    input  logic         arm_bit,
    input  logic         stop,
    output speed_state_t state
);

    speed_state_t nxt;

    always_comb begin
        nxt = state;
        if (stop && state.armed) begin
            nxt.double_spd = ~state.double_spd;
            nxt.armed      = 1'b0;
        end else if (wr_speed) begin
            nxt.armed = arm_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

    // R7: an armed stop toggles the speed and disarms
    a_r7_switch: assert property (@(posedge clk) disable iff (rst)
        (stop && state.armed) |=> (state.double_spd != $past(state.double_spd)) && !state.armed);
    // R7: without an armed stop the speed is unchanged
    a_r7_speed_hold: assert property (@(posedge clk) disable iff (rst)
        !(stop && state.armed) |=> $stable(state.double_spd));
    // R6: a plain write sets the arm bit from data bit 0
    a_r6_arm_load: assert property (@(posedge clk) disable iff (rst)
        (wr_speed && !(stop && state.armed)) |=> (state.armed == $past(arm_bit)));

endmodule

// File: rtl/compat_reg.sv
module compat_reg
    import irqspd_pkg::*;
#(
    parameter int              DATA_W      = BUS_W,
    parameter logic [DATA_W-1:0] LEGACY_CODE = DATA_W'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_compat,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              legacy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= '0;
            legacy <= 1'b0;
        end else if (wr_compat) begin
            value <= wdata;
            if (wdata == LEGACY_CODE) legacy <= 1'b1;
        end
    end

    // R8: the legacy indication is sticky
    a_r8_legacy_sticky: assert property (@(posedge clk) disable iff (rst)
        legacy |=> legacy);
    // R8: writing the code turns the indication on
    a_r8_legacy_set: assert property (@(posedge clk) disable iff (rst)
        (wr_compat && wdata == LEGACY_CODE) |=> legacy);

endmodule

// File: rtl/irqspd_regs.sv
module irqspd_regs
    import irqspd_pkg::*;
#(
    parameter logic [7:0] ADDR_FLAG   = 8'h0F,
    parameter logic [7:0] ADDR_MASK   = 8'hFF,
    parameter logic [7:0] ADDR_COMPAT = 8'h4C,
    parameter logic [7:0] ADDR_SPEED  = 8'h4D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               cpu_stop,
    output logic [NUM_SRC-1:0] irq_pending,
    output logic               speed_double,
    output logic               legacy_mode
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] flags;
    logic [BUS_W-1:0]   mask;
    logic [BUS_W-1:0]   compat_val;
    speed_state_t       spd;

    always_comb begin
        unique case (bus_addr)
            ADDR_FLAG:   sel = SEL_FLAG;
            ADDR_MASK:   sel = SEL_MASK;
            ADDR_COMPAT: sel = SEL_COMPAT;
            ADDR_SPEED:  sel = SEL_SPEED;
            default:     sel = SEL_NONE;
        endcase
    end

    irq_flag_bank #(.SRC_N(NUM_SRC), .DATA_W(BUS_W)) flag_bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_flag (bus_wr && sel == SEL_FLAG),
        .wr_mask (bus_wr && sel == SEL_MASK),
        .wdata   (bus_wdata),
        .req     (irq_req),
        .flags   (flags),
        .mask    (mask),
        .pending (irq_pending)
    );

    speed_ctl speed_ctl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_speed (bus_wr && sel == SEL_SPEED),
        .arm_bit  (bus_wdata[0]),
        .stop     (cpu_stop),
        .state    (spd)
    );

    compat_reg #(.DATA_W(BUS_W)) compat_i (
        .clk       (clk),
        .rst       (rst),
        .wr_compat (bus_wr && sel == SEL_COMPAT),
        .wdata     (bus_wdata),
        .value     (compat_val),
        .legacy    (legacy_mode)
    );

    assign speed_double = spd.double_spd;

    always_comb begin
        unique case (sel)
            SEL_FLAG:   bus_rdata = widen_flags(flags);
            SEL_MASK:   bus_rdata = mask;
            SEL_COMPAT: bus_rdata = compat_val;
            SEL_SPEED:  bus_rdata = speed_readback(spd);
            default:    bus_rdata = '0;
        endcase
    end

    // R9: a write to an unmapped address leaves every register alone
    a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE && irq_req == '0 && !cpu_stop)
            |=> ($stable(mask) && $stable(compat_val) && $stable(flags) && $stable(spd)));
    // R1: reset clears the visible state
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (irq_pending == '0 && !speed_double && !legacy_mode));

endmodule

// File: tb/irqspd_regs_tb.sv
`timescale 1ns/100ps
module irqspd_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] irq_req = '0;
    logic       cpu_stop = 1'b0;
    logic [4:0] irq_pending;
    logic       speed_double;
    logic       legacy_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqspd_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .cpu_stop(cpu_stop), .irq_pending(irq_pending),
        .speed_double(speed_double), .legacy_mode(legacy_mode)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic stop_pulse();
        @(negedge clk);
        cpu_stop = 1'b1;
        @(negedge clk);
        cpu_stop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();

        // R1: reset state
        rd(8'h0F, v); check("R1 flags", v, 8'h00);
        rd(8'hFF, v); check("R1 mask", v, 8'h00);
        rd(8'h4C, v); check("R1 compat", v, 8'h00);
        rd(8'h4D, v); check("R1 speed", v, 8'h00);
        check("R1 pending", {3'b0, irq_pending}, 8'h00);
        check("R1 legacy", {7'b0, legacy_mode}, 8'h00);
        check("R1 speed_double", {7'b0, speed_double}, 8'h00);

        // R2: every write value to the flag register
        for (int d = 0; d < 256; d++) begin
            wr(8'h0F, 8'(d));
            rd(8'h0F, v);
            check("R2 flag write/read", v, 8'(d) & 8'h1F);
        end

        // R4: every mask value
        for (int d = 0; d < 256; d++) begin
            wr(8'hFF, 8'(d));
            rd(8'hFF, v);
            check("R4 mask readback", v, 8'(d));
        end

        // R5: all flag and mask combinations on bits 4:0
        for (int f = 0; f < 32; f++) begin
            wr(8'h0F, 8'(f));
            for (int m = 0; m < 32; m++) begin
                wr(8'hFF, 8'(m) | 8'hE0);
                check("R5 pending", {3'b0, irq_pending}, 8'(f & m));
            end
        end

        // R3: request alone, and request against a clearing write
        for (int i = 0; i < 5; i++) begin
            wr(8'h0F, 8'h00);
            @(negedge clk);
            irq_req = 5'(1 << i);
            @(negedge clk);
            irq_req = '0;
            rd(8'h0F, v);
            check("R3 request sets", v, 8'(1 << i));

            @(negedge clk);
            bus_addr = 8'h0F; bus_wdata = 8'h00; bus_wr = 1'b1;
            irq_req = 5'(1 << i);
            @(negedge clk);
            bus_wr = 1'b0; irq_req = '0;
            rd(8'h0F, v);
            check("R3 request beats clear", v, 8'(1 << i));
        end

        // R6: arm bit write and readback
        wr(8'h4D, 8'h01); rd(8'h4D, v); check("R6 arm set", v, 8'h01);
        wr(8'h4D, 8'h00); rd(8'h4D, v); check("R6 arm clear", v, 8'h00);
        wr(8'h4D, 8'hFE); rd(8'h4D, v); check("R6 other bits ignored", v, 8'h00);

        // R7: stop strobes, armed and unarmed
        stop_pulse(); rd(8'h4D, v); check("R7 unarmed stop", v, 8'h00);
        check("R7 speed_double normal", {7'b0, speed_double}, 8'h00);
        wr(8'h4D, 8'h01); stop_pulse();
        rd(8'h4D, v); check("R7 switch to double", v, 8'h80);
        check("R7 speed_double high", {7'b0, speed_double}, 8'h01);
        stop_pulse(); rd(8'h4D, v); check("R7 second stop unarmed", v, 8'h80);
        wr(8'h4D, 8'h01); rd(8'h4D, v); check("R7 armed at double", v, 8'h81);
        stop_pulse(); rd(8'h4D, v); check("R7 switch back", v, 8'h00);

        // R8: compatibility register and sticky legacy output
        wr(8'h4C, 8'h80); rd(8'h4C, v); check("R8 compat rw", v, 8'h80);
        check("R8 legacy off", {7'b0, legacy_mode}, 8'h00);
        wr(8'h4C, 8'h04); check("R8 legacy on", {7'b0, legacy_mode}, 8'h01);
        wr(8'h4C, 8'h00); rd(8'h4C, v); check("R8 compat cleared", v, 8'h00);
        check("R8 legacy sticky", {7'b0, legacy_mode}, 8'h01);

        // R9: unmapped addresses
        wr(8'h0F, 8'h15); wr(8'hFF, 8'h3C);
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h0F && a != 8'hFF && a != 8'h4C && a != 8'h4D) begin
                wr(8'(a), 8'hFF);
                rd(8'(a), v);
                check("R9 unmapped reads zero", v, 8'h00);
            end
        end
        rd(8'h0F, v); check("R9 flags untouched", v, 8'h15);
        rd(8'hFF, v); check("R9 mask untouched", v, 8'h3C);
        rd(8'h4C, v); check("R9 compat untouched", v, 8'h00);
        rd(8'h4D, v); check("R9 speed untouched", v, 8'h00);

        // R1: reset clears the sticky and speed state as well
        wr(8'h4D, 8'h01); stop_pulse();
        do_reset();
        check("R1 legacy after reset", {7'b0, legacy_mode}, 8'h00);
        check("R1 speed after reset", {7'b0, speed_double}, 8'h00);
        rd(8'h0F, v); check("R1 flags after reset", v, 8'h00);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule